// File: doc/BRIEF.md
# Daisy-Chain Serial DAC Host Writer

This block is the host side of a three-wire link that programs a chain of dual-channel, 12-bit serial DACs. The data output of each device feeds the data input of the next, so the chain behaves as one long shift register that `NUM_DEV` devices share. A single pulse on `start` captures all `2*NUM_DEV` codes from a flat parallel bus. The block then emits one frame: it lowers the select/load line, clocks out every bit, and raises select/load again. That rising edge latches the new codes into every device at the same moment.

Every timing minimum on the link is a parameter counted in system-clock cycles. This covers select-to-first-clock, data setup, clock high, clock low, last-clock-to-load and the select-high gap between frames. The defaults suit a 100 MHz system clock. The serial clock idles low and data changes only on its falling edge. The block reports `busy` for the whole transaction and pulses `done` for one cycle at the end of it.

Top module: `dac_chain_writer`

## Requirements
- R1: During and right after reset, `sel_n` is 1, `sclk` is 0, `busy` is 0 and `done` is 0.
- R2: A frame contains exactly `2*CODE_W*NUM_DEV` rising edges of `sclk`. The code bus holds device d (0 is nearest the host) in bits `[2*CODE_W*d +: 2*CODE_W]`, with its channel A code in the upper `CODE_W` bits and its channel B code in the lower bits. On the wire, the farthest device's word goes first, channel A before channel B, and each code is sent MSB first.
- R3: The clock edge that accepts `start` in idle also drives `sel_n` low and `busy` high. The first `sclk` rise follows exactly `T_SEL_SU + LOW_CYC` cycles after `sel_n` falls, where `LOW_CYC = max(T_CLK_LOW, T_DATA_SU)`.
- R4: Each `sclk` high phase lasts exactly `T_CLK_HIGH` cycles. Each low phase between two rises lasts exactly `LOW_CYC` cycles.
- R5: While `sel_n` is low, `sdo` changes only in the cycle where `sclk` falls or `sel_n` falls. It is stable for at least `T_DATA_SU` cycles before every `sclk` rise.
- R6: `sclk` is low whenever `sel_n` is high. `sel_n` rises exactly `T_CLK_HIGH + T_LOAD` cycles after the last `sclk` rise.
- R7: `done` is high for exactly one cycle. It rises `T_DESEL` cycles after `sel_n` rises, with `sel_n` still high, and `busy` is low in the cycle after `done`.
- R8: A `start` seen while `busy` is high is ignored. No extra frame follows, even when `start` stays high through the end of the transaction.
- R9: Codes are captured on the accepting edge. Changes on the code bus during a frame have no effect on the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one frame; sampled only when idle |
| codes | input | 2*CODE_W*NUM_DEV | Packed codes, device-major, channel A high |
| sclk | output | 1 | Serial clock to the chain, idles low |
| sdo | output | 1 | Serial data to the first device's data input |
| sel_n | output | 1 | Select (low) and load (rising edge) for all devices |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |

## Verification
Several properties are checked on every cycle by assertions:
- `sclk` stays low while deselected.
- The clock high phase has the exact length.
- `sdo` moves only on a falling clock or on select entry.
- `done` is a single-cycle pulse, issued while deselected.
- A busy transaction does not drop out early.

Other behaviour can only be shown by the bench's scenarios. These cover the bit order across devices and channels, the total bit count, the select-to-clock and clock-to-load spacing, and the deselect gap before `done`. They also cover the fact that codes are frozen at acceptance and that a held or repeated `start` never produces a second frame.

// File: rtl/dcw_pkg.sv
// Package: shared sequencer state encoding for the chain writer.
// Assumes: nothing beyond the importing modules using the same encoding.
package dcw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL_SETUP,
        ST_CLK_LOW,
        ST_CLK_HIGH,
        ST_LOAD_WAIT,
        ST_DESEL_HOLD,
        ST_DONE
    } dcw_state_e;
endpackage

// File: rtl/dcw_phase_timer.sv
// Module: down-counting phase timer. Loading value V makes `expired`
// assert in the V+1-th cycle after the load edge, so a state that loads
// duration-1 on entry lasts exactly `duration` cycles.
// Assumes: load has priority; the counter rests at zero.
module dcw_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Count the loaded duration down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dcw_frame_shifter.sv
// Module: frame shift register and bit counter. Captures the whole frame
// in parallel, presents its MSB on sdo and shifts left on request.
// Assumes: capture and shift are never requested together.
module dcw_frame_shifter #(
    parameter int FRAME_W = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               shift,
    output logic               sdo,
    output logic               last_bit
);
    localparam int BC_W = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] shreg_q;
    logic [BC_W-1:0]    bit_cnt_q;

    // Load the frame on capture, move one bit toward the MSB on shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            bit_cnt_q <= '0;
        end else if (capture) begin
            shreg_q   <= frame_in;
            bit_cnt_q <= '0;
        end else if (shift) begin
            shreg_q   <= {shreg_q[FRAME_W-2:0], 1'b0};
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    assign sdo      = shreg_q[FRAME_W-1];
    assign last_bit = (bit_cnt_q == BC_W'(FRAME_W - 1));

    AST_SHIFT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> (bit_cnt_q < BC_W'(FRAME_W))); // R2
    AST_CAPTURE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !shift); // R9
endmodule

// File: rtl/dcw_sequencer.sv
// Module: link sequencer. Walks idle, select setup, clock low/high per bit,
// load wait, deselect hold and done. It times each phase through the
// phase timer and drives registered link outputs from the next state.
// Assumes: every timing parameter is at least 1.
module dcw_sequencer
    import dcw_pkg::*;
#(
    parameter int T_SEL_SU   = 2,
    parameter int T_DATA_SU  = 5,
    parameter int T_CLK_LOW  = 4,
    parameter int T_CLK_HIGH = 4,
    parameter int T_LOAD     = 4,
    parameter int T_DESEL    = 5,
    parameter int TW         = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          expired,
    input  logic          last_bit,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          capture,
    output logic          shift,
    output logic          sclk,
    output logic          sel_n,
    output logic          busy,
    output logic          done
);
    localparam int LOW_CYC = (T_CLK_LOW > T_DATA_SU) ? T_CLK_LOW : T_DATA_SU;

    dcw_state_e state_q, state_d;

    // Choose the next phase and the duration to load on entry to it.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        shift    = 1'b0;
        case (state_q)
            ST_IDLE: if (start) begin
                state_d  = ST_SEL_SETUP;
                capture  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = TW'(T_SEL_SU - 1);
            end
            ST_SEL_SETUP: if (expired) begin
                state_d  = ST_CLK_LOW;
                tmr_load = 1'b1;
                tmr_val  = TW'(LOW_CYC - 1);
            end
            ST_CLK_LOW: if (expired) begin
                state_d  = ST_CLK_HIGH;
                tmr_load = 1'b1;
                tmr_val  = TW'(T_CLK_HIGH - 1);
            end
            ST_CLK_HIGH: if (expired) begin
                shift    = 1'b1;
                tmr_load = 1'b1;
                if (last_bit) begin
                    state_d = ST_LOAD_WAIT;
                    tmr_val = TW'(T_LOAD - 1);
                end else begin
                    state_d = ST_CLK_LOW;
                    tmr_val = TW'(LOW_CYC - 1);
                end
            end
            ST_LOAD_WAIT: if (expired) begin
                state_d  = ST_DESEL_HOLD;
                tmr_load = 1'b1;
                tmr_val  = TW'(T_DESEL - 1);
            end
            ST_DESEL_HOLD: if (expired) state_d = ST_DONE;
            ST_DONE:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Advance the state and register link outputs decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sclk    <= 1'b0;
            sel_n   <= 1'b1;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            sclk    <= (state_d == ST_CLK_HIGH);
            sel_n   <= !(state_d == ST_SEL_SETUP || state_d == ST_CLK_LOW ||
                         state_d == ST_CLK_HIGH  || state_d == ST_LOAD_WAIT);
            busy    <= (state_d != ST_IDLE);
            done    <= (state_d == ST_DONE);
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sel_n && busy)); // R7
endmodule

// File: rtl/dac_chain_writer.sv
// Module: top of the daisy-chain DAC writer. Device d of the chain (0 next
// to the host) sits in codes[2*CODE_W*d +: 2*CODE_W], channel A high. The
// top bit of the bus is therefore the farthest device's channel A MSB, and
// the bus is the serial frame as is, sent MSB first.
// Assumes: 1 <= NUM_DEV <= 8 and all timing parameters >= 1.
module dac_chain_writer #(
    parameter int NUM_DEV    = 2,
    parameter int CODE_W     = 12,
    parameter int T_SEL_SU   = 2,
    parameter int T_DATA_SU  = 5,
    parameter int T_CLK_LOW  = 4,
    parameter int T_CLK_HIGH = 4,
    parameter int T_LOAD     = 4,
    parameter int T_DESEL    = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [2*CODE_W*NUM_DEV-1:0]  codes,
    output logic                         sclk,
    output logic                         sdo,
    output logic                         sel_n,
    output logic                         busy,
    output logic                         done
);
    localparam int FRAME_W = 2 * CODE_W * NUM_DEV;
    localparam int LOW_CYC = (T_CLK_LOW > T_DATA_SU) ? T_CLK_LOW : T_DATA_SU;
    localparam int MAX_A   = (T_SEL_SU > LOW_CYC) ? T_SEL_SU : LOW_CYC;
    localparam int MAX_B   = (T_CLK_HIGH > T_LOAD) ? T_CLK_HIGH : T_LOAD;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_D   = (MAX_C > T_DESEL) ? MAX_C : T_DESEL;
    localparam int TW      = $clog2(MAX_D + 1);
    localparam int HW      = $clog2(T_CLK_HIGH + 2);

    logic          tmr_load, expired, capture, shift, last_bit;
    logic [TW-1:0] tmr_val;

    dcw_phase_timer #(.CNT_W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    dcw_frame_shifter #(.FRAME_W(FRAME_W)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .frame_in (codes),
        .shift    (shift),
        .sdo      (sdo),
        .last_bit (last_bit)
    );

    dcw_sequencer #(
        .T_SEL_SU   (T_SEL_SU),
        .T_DATA_SU  (T_DATA_SU),
        .T_CLK_LOW  (T_CLK_LOW),
        .T_CLK_HIGH (T_CLK_HIGH),
        .T_LOAD     (T_LOAD),
        .T_DESEL    (T_DESEL),
        .TW         (TW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .expired  (expired),
        .last_bit (last_bit),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .capture  (capture),
        .shift    (shift),
        .sclk     (sclk),
        .sel_n    (sel_n),
        .busy     (busy),
        .done     (done)
    );

    // Measure the length of each serial clock high phase for the check below.
    logic [HW-1:0] hi_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !sclk)
            hi_run_q <= '0;
        else if (hi_run_q != '1)
            hi_run_q <= hi_run_q + 1'b1;
    end

    AST_CLK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> !sclk); // R6
    AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_run_q == HW'(T_CLK_HIGH))); // R4
    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdo) && !sel_n) |-> ($fell(sclk) || $fell(sel_n))); // R5
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R8
endmodule

// File: tb/dac_chain_writer_bench.sv
module dac_chain_writer_bench;
    localparam int NUM_DEV    = 2;
    localparam int CODE_W     = 12;
    localparam int T_SEL_SU   = 2;
    localparam int T_DATA_SU  = 5;
    localparam int T_CLK_LOW  = 4;
    localparam int T_CLK_HIGH = 4;
    localparam int T_LOAD     = 4;
    localparam int T_DESEL    = 5;
    localparam int FW         = 2 * CODE_W * NUM_DEV;
    localparam int LOW_CYC    = (T_CLK_LOW > T_DATA_SU) ? T_CLK_LOW : T_DATA_SU;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, start;
    logic [FW-1:0] codes;
    logic          sclk, sdo, sel_n, busy, done;

    dac_chain_writer #(
        .NUM_DEV(NUM_DEV), .CODE_W(CODE_W), .T_SEL_SU(T_SEL_SU),
        .T_DATA_SU(T_DATA_SU), .T_CLK_LOW(T_CLK_LOW), .T_CLK_HIGH(T_CLK_HIGH),
        .T_LOAD(T_LOAD), .T_DESEL(T_DESEL)
    ) u_dac_chain_writer (
        .clk(clk), .rst_n(rst_n), .start(start), .codes(codes),
        .sclk(sclk), .sdo(sdo), .sel_n(sel_n), .busy(busy), .done(done)
    );

    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string req,
                         input logic [FW-1:0] act, input logic [FW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pack per-device codes onto the bus: device d at [2*CODE_W*d], A high.
    function automatic logic [FW-1:0] pack(input logic [CODE_W-1:0] a[NUM_DEV],
                                           input logic [CODE_W-1:0] b[NUM_DEV]);
        logic [FW-1:0] v = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            v[2*CODE_W*d + CODE_W +: CODE_W] = a[d];
            v[2*CODE_W*d +: CODE_W]          = b[d];
        end
        return v;
    endfunction

    // Expected wire order: farthest device first, A then B, MSB first.
    function automatic logic [FW-1:0] expect_frame(input logic [CODE_W-1:0] a[NUM_DEV],
                                                   input logic [CODE_W-1:0] b[NUM_DEV]);
        logic [FW-1:0] f = '0;
        for (int d = NUM_DEV - 1; d >= 0; d--) begin
            f = (f << CODE_W) | FW'(a[d]);
            f = (f << CODE_W) | FW'(b[d]);
        end
        return f;
    endfunction

    // Link monitor: timing of every edge and the captured bit stream.
    int  cyc = 0;
    bit  mon_on = 0;
    logic p_sclk = 1'b0, p_sel = 1'b1, p_sdo = 1'b0, p_done = 1'b0;
    int  t_sel_fall = 0, t_last_rise = 0, t_last_fall = 0, t_sel_rise = 0, t_sdo_chg = 0;
    int  nbits = 0, nframes = 0;
    logic [FW-1:0] cap = '0;

    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            if (p_sel && !sel_n) begin
                t_sel_fall = cyc; nbits = 0; cap = '0; nframes++; t_sdo_chg = cyc;
            end
            if (sdo !== p_sdo) begin
                if (!sel_n)
                    check((p_sclk && !sclk) || (p_sel && !sel_n), "R5 data moved off falling edge",
                          FW'(sdo), FW'(p_sdo));
                t_sdo_chg = cyc;
            end
            if (!p_sclk && sclk) begin
                check(!sel_n, "R6 clock while deselected", FW'(sel_n), '0);
                if (nbits == 0)
                    check(cyc - t_sel_fall == T_SEL_SU + LOW_CYC, "R3 select to first clock",
                          FW'(cyc - t_sel_fall), FW'(T_SEL_SU + LOW_CYC));
                else
                    check(cyc - t_last_fall == LOW_CYC, "R4 clock low phase",
                          FW'(cyc - t_last_fall), FW'(LOW_CYC));
                check(cyc - t_sdo_chg >= T_DATA_SU, "R5 data setup",
                      FW'(cyc - t_sdo_chg), FW'(T_DATA_SU));
                cap = {cap[FW-2:0], sdo};
                nbits++;
                t_last_rise = cyc;
            end
            if (p_sclk && !sclk) begin
                check(cyc - t_last_rise == T_CLK_HIGH, "R4 clock high phase",
                      FW'(cyc - t_last_rise), FW'(T_CLK_HIGH));
                t_last_fall = cyc;
            end
            if (!p_sel && sel_n) begin
                check(cyc - t_last_rise == T_CLK_HIGH + T_LOAD, "R6 last clock to load",
                      FW'(cyc - t_last_rise), FW'(T_CLK_HIGH + T_LOAD));
                check(nbits == FW, "R2 bit count", FW'(nbits), FW'(FW));
                t_sel_rise = cyc;
            end
            if (done && !p_done)
                check(sel_n && (cyc - t_sel_rise == T_DESEL), "R7 deselect hold before done",
                      FW'(cyc - t_sel_rise), FW'(T_DESEL));
            if (done && p_done)
                check(1'b0, "R7 done longer than one cycle", 2, 1);
        end
        p_sclk = sclk; p_sel = sel_n; p_sdo = sdo; p_done = done;
    end

    task automatic run_frame(input logic [CODE_W-1:0] a[NUM_DEV],
                             input logic [CODE_W-1:0] b[NUM_DEV],
                             input bit disturb, input bit hold_start, input int gap);
        int nf0 = nframes;
        int n = 0;
        logic [FW-1:0] exp = expect_frame(a, b);
        codes = pack(a, b);
        start = 1'b1;
        @(negedge clk);
        check(busy && !sel_n, "R3 accept edge selects", FW'({busy, sel_n}), FW'(2'b10));
        if (!hold_start) start = 1'b0;
        if (disturb) begin
            repeat (30) @(negedge clk);
            codes = ~codes;
            start = 1'b1;
            @(negedge clk);
            if (!hold_start) start = 1'b0;
        end
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        if (disturb) check(cap == exp, "R9 codes frozen at accept", cap, exp);
        else         check(cap == exp, "R2 frame order", cap, exp);
        check(nframes == nf0 + 1, "R8 one frame per accept", FW'(nframes - nf0), 1);
        @(negedge clk);
        check(!busy && !done, "R7 idle after done", FW'({busy, done}), '0);
        repeat (gap) @(negedge clk);
        check(nframes == nf0 + 1 && sel_n, "R8 no extra frame", FW'(nframes - nf0), 1);
    endtask

    initial begin
        logic [CODE_W-1:0] a[NUM_DEV];
        logic [CODE_W-1:0] b[NUM_DEV];
        void'($urandom(32'h1590_5eed));
        rst_n = 1'b0; start = 1'b0; codes = '0;
        repeat (4) @(negedge clk);
        check(sel_n && !sclk && !busy && !done, "R1 reset state",
              FW'({sel_n, sclk, busy, done}), FW'(4'b1000));
        start = 1'b1;
        @(negedge clk);
        check(sel_n && !busy, "R1 start ignored in reset", FW'({sel_n, busy}), FW'(2'b10));
        start = 1'b0;
        rst_n = 1'b1;
        mon_on = 1;
        @(negedge clk);
        check(sel_n && !sclk && !busy && !done, "R1 idle after reset",
              FW'({sel_n, sclk, busy, done}), FW'(4'b1000));

        for (int d = 0; d < NUM_DEV; d++) begin a[d] = '0; b[d] = '0; end
        run_frame(a, b, 0, 0, 3);
        for (int d = 0; d < NUM_DEV; d++) begin a[d] = '1; b[d] = '1; end
        run_frame(a, b, 0, 0, 2);
        for (int d = 0; d < NUM_DEV; d++) begin
            a[d] = CODE_W'(1) << (CODE_W - 1 - d);
            b[d] = CODE_W'(1) << d;
        end
        run_frame(a, b, 0, 0, 1);
        for (int d = 0; d < NUM_DEV; d++) begin a[d] = 12'hA5A; b[d] = 12'h5A5; end
        run_frame(a, b, 0, 1, 20);
        for (int d = 0; d < NUM_DEV; d++) begin a[d] = 12'h3C1 + 12'(d); b[d] = 12'hC3E - 12'(d); end
        run_frame(a, b, 1, 0, 5);
        for (int i = 0; i < 6; i++) begin
            for (int d = 0; d < NUM_DEV; d++) begin
                a[d] = CODE_W'($urandom);
                b[d] = CODE_W'($urandom);
            end
            run_frame(a, b, (i % 3) == 1, (i % 2) == 1, i % 4);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R7 watchdog actual=no_done expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule